// File: doc/BRIEF.md
# Two-Way Set-Associative Lookup Unit with LRU Replacement

This block is a small read cache of word-sized blocks arranged as a number of sets with two ways each. A request carries a block address. The low address bits select the set, because the set index is the block number modulo the set count. The remaining bits form the tag. Both ways of the selected set are compared in the same cycle, with one comparator per way. A hit returns the stored word together with the way that matched.

A miss starts a refill. The block sends one request pulse to memory and holds the address steady. It then waits a fixed number of cycles, takes the word presented on the memory data input, writes it into a victim way and returns it. The victim is an invalid way when the set has one, with way 0 tried first. When both ways are valid, the victim is the least-recently-used way. Each set tracks this with a single bit that is flipped to point at the other way after every hit and every fill. While a refill is pending, `ready` is low and new requests are not taken.

Top module: `cache2w_lru`

## Requirements
- R1: After reset, `ready` is 1, `resp_valid` is 0 and `mem_req` is 0. Every valid bit and every LRU bit is cleared, so the first access to any set misses and fills way 0.
- R2: The set index is `req_addr` modulo NUM_SETS, which is its low log2(NUM_SETS) bits. Fills and LRU updates in one set never change the contents or the hit/miss outcome of another set.
- R3: A request accepted while `ready` is 1 that matches a valid tag in its set produces `resp_valid`=1, `resp_hit`=1, `resp_way` equal to the matching way and `resp_data` equal to the stored word. This appears in the cycle right after the accepting clock edge, and no memory request is made.
- R4: A request that misses drives `mem_req` high for exactly one cycle right after the accepting edge, with `mem_addr` equal to the block address. `mem_addr` stays stable and `ready` stays low until the response. The response comes REFILL_LAT cycles later than a hit's would, with `resp_hit`=0, `resp_way` equal to the victim, and `resp_data` equal to `mem_rdata` as it stood at the filling edge.
- R5: On a miss, an invalid way is chosen as the victim: way 0 if it is invalid, otherwise way 1 if that is invalid.
- R6: When both ways of the set are valid, the victim is the way indicated by the set's LRU bit. That bit is set to point at the other way after every hit and every fill in that set.
- R7: With NUM_SETS=2, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss, and all five blocks fall in set 0.
- R8: `req_valid` is ignored while `ready` is 0. Such a request produces no response, no memory request and no fill.
- R9: Each accepted request yields exactly one `resp_valid` pulse of one cycle, and `resp_valid` and `mem_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Block address of the request |
| ready | output | 1 | Request accepted at this edge when high with req_valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 for a hit, 0 for a refilled miss |
| resp_way | output | 1 | Way that hit or was filled |
| resp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | One-cycle refill request pulse |
| mem_addr | output | ADDR_W | Block address being refilled, held during the refill |
| mem_rdata | input | DATA_W | Refill word, sampled REFILL_LAT edges after the request pulse is raised |

## Verification
A hit response is due at the first falling edge after the accepting rising edge. A miss response is due REFILL_LAT cycles after that. The request pulse and the low `ready` show up at that same first falling edge. The driver reads the edge count on the falling edge before it presents each request and stores the due cycle with the expected hit flag, way and word in a queue. The monitor samples only at falling edges. When `resp_valid` is high it pops one entry and compares the cycle number as well as the fields, so an early, late, extra or missing response is reported against the requirement it breaks.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_FILL = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic hit;
        logic way;
        logic victim;
    } lookup_t;

    // Invalid ways win over the LRU pointer; way 0 is tried first.
    function automatic logic pick_victim(input logic [NUM_WAYS-1:0] vld, input logic lru_ptr);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru_ptr;
    endfunction

endpackage

// File: rtl/c2w_tag_array.sv
module c2w_tag_array
    import cache2w_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int TAG_W    = 7,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             upd_en,
    input  logic             upd_fill,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way,
    input  logic [TAG_W-1:0] upd_tag,
    output lookup_t          lk
);

    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] vld_at;
    logic [NUM_SETS-1:0] lru_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0]    tag_q [NUM_SETS];
        logic [NUM_SETS-1:0] vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                for (int s = 0; s < NUM_SETS; s++) tag_q[s] <= '0;
            end else if (upd_en && upd_fill && (upd_way == w[0])) begin
                vld_q[upd_set] <= 1'b1;
                tag_q[upd_set] <= upd_tag;
            end
        end

        assign vld_at[w] = vld_q[lk_set];
        assign match[w]  = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (upd_en) begin
            lru_q[upd_set] <= ~upd_way;
        end
    end

    always_comb begin
        lk.hit    = |match;
        lk.way    = match[1];
        lk.victim = pick_victim(vld_at, lru_q[lk_set]);
    end

endmodule

// File: rtl/c2w_data_array.sv
module c2w_data_array
    import cache2w_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int DATA_W   = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic              rd_way,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] way_word [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_bank
        logic [DATA_W-1:0] mem_q [NUM_SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NUM_SETS; s++) mem_q[s] <= '0;
            end else if (wr_en && (wr_way == w[0])) begin
                mem_q[wr_set] <= wr_data;
            end
        end

        assign way_word[w] = mem_q[rd_set];
    end

    assign rd_data = way_word[rd_way];

endmodule

// File: rtl/c2w_refill_ctl.sv
module c2w_refill_ctl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REFILL_LAT = 4,
    localparam int CNT_W     = $clog2(REFILL_LAT) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_victim,
    output logic              idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fill_way,
    output logic              fill_done
);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CTL_IDLE;
            cnt_q     <= '0;
            mem_req   <= 1'b0;
            fill_addr <= '0;
            fill_way  <= 1'b0;
        end else begin
            mem_req <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (start) begin
                        state_q   <= CTL_FILL;
                        cnt_q     <= CNT_W'(REFILL_LAT - 1);
                        mem_req   <= 1'b1;
                        fill_addr <= start_addr;
                        fill_way  <= start_victim;
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= CTL_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign idle      = (state_q == CTL_IDLE);
    assign fill_done = (state_q == CTL_FILL) && (cnt_q == '0);

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
    import cache2w_pkg::*;
#(
    parameter int NUM_SETS   = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int REFILL_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_way,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int SET_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - SET_W;

    lookup_t           lk;
    logic              accept;
    logic              fill_done;
    logic              fill_way;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] hit_word;
    logic              upd_en;
    logic [SET_W-1:0]  upd_set;
    logic              upd_way;

    assign accept = req_valid && ready;

    c2w_tag_array #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_set   (req_addr[SET_W-1:0]),
        .lk_tag   (req_addr[ADDR_W-1:SET_W]),
        .upd_en   (upd_en),
        .upd_fill (fill_done),
        .upd_set  (upd_set),
        .upd_way  (upd_way),
        .upd_tag  (fill_addr[ADDR_W-1:SET_W]),
        .lk       (lk)
    );

    c2w_data_array #(.NUM_SETS(NUM_SETS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fill_done),
        .wr_set  (fill_addr[SET_W-1:0]),
        .wr_way  (fill_way),
        .wr_data (mem_rdata),
        .rd_set  (req_addr[SET_W-1:0]),
        .rd_way  (lk.way),
        .rd_data (hit_word)
    );

    c2w_refill_ctl #(.ADDR_W(ADDR_W), .REFILL_LAT(REFILL_LAT)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .start        (accept && !lk.hit),
        .start_addr   (req_addr),
        .start_victim (lk.victim),
        .idle         (ready),
        .mem_req      (mem_req),
        .fill_addr    (fill_addr),
        .fill_way     (fill_way),
        .fill_done    (fill_done)
    );

    assign mem_addr = fill_addr;

    // A fill and an accepted hit cannot coincide: ready is low while filling.
    assign upd_en  = fill_done || (accept && lk.hit);
    assign upd_set = fill_done ? fill_addr[SET_W-1:0] : req_addr[SET_W-1:0];
    assign upd_way = fill_done ? fill_way : lk.way;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (fill_done) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b0;
                resp_way   <= fill_way;
                resp_data  <= mem_rdata;
            end else if (accept && lk.hit) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b1;
                resp_way   <= lk.way;
                resp_data  <= hit_word;
            end
        end
    end

endmodule

// File: rtl/cache2w_lru_chk.sv
module cache2w_lru_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R4

    AST_REQ_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ready); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!ready && $past(!ready)) |-> $stable(mem_addr)); // R4

    AST_READY_WITH_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (resp_valid && !resp_hit)); // R4

    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (resp_valid || mem_req)); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && mem_req)); // R9

    AST_HIT_NOT_DURING_FILL: assert property (@(posedge clk) disable iff (rst)
        (!$past(ready) && !ready) |-> !resp_valid); // R8

endmodule

bind cache2w_lru cache2w_lru_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .ready      (ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr)
);

// File: tb/sim_cache2w_lru.sv
`timescale 1ns/1ps
module sim_cache2w_lru;

    localparam int NUM_SETS   = 2;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int REFILL_LAT = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              ready;
    logic              resp_valid;
    logic              resp_hit;
    logic              resp_way;
    logic [DATA_W-1:0] resp_data;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;

    always #10 clk = ~clk;

    // Memory word for each block address, presented for as long as the address is held.
    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {8'hA5, a} ^ 16'h0F00;
    endfunction
    assign mem_rdata = mem_word(mem_addr);

    cache2w_lru #(
        .NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REFILL_LAT(REFILL_LAT)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .ready(ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_data(resp_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_bad    = 0;
    int cyc      = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic              hit;
        logic              way;
        logic [DATA_W-1:0] data;
        int                due;
        string             rq;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every response strobe.
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected response, cycle", cyc, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, e.rq, "response cycle", cyc, e.due);
                check(resp_hit == e.hit, e.rq, "hit flag", resp_hit, e.hit);
                check(resp_way == e.way, e.rq, "way", resp_way, e.way);
                check(resp_data == e.data, e.rq, "data", resp_data, e.data);
            end
        end
    end

    // Driver: called at a falling edge with ready high. noise!=0 drives an extra
    // request while the refill is pending; it must be ignored (R8).
    task automatic issue(input logic [ADDR_W-1:0] a, input logic eh, input logic ew,
                         input string rq, input bit noise = 1'b0,
                         input logic [ADDR_W-1:0] noise_addr = '0);
        exp_t e;
        e.hit  = eh;
        e.way  = ew;
        e.data = mem_word(a);
        e.due  = eh ? cyc + 1 : cyc + 1 + REFILL_LAT;
        e.rq   = rq;
        sb.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (eh) begin
            check(mem_req == 1'b0, rq, "R3 no memory request on hit", mem_req, 0);
        end else begin
            check(mem_req == 1'b1, rq, "R4 memory request pulse", mem_req, 1);
            check(mem_addr == a, rq, "R4 memory address", mem_addr, a);
            check(ready == 1'b0, rq, "R4 ready low during refill", ready, 0);
            if (noise) begin
                req_valid = 1'b1;
                req_addr  = noise_addr;
                repeat (2) @(negedge clk);
                req_valid = 1'b0;
            end
        end
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1", "ready in reset", ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R1", "ready after reset", ready, 1);

        // R7 sequence in set 0: miss, miss, hit, miss, miss
        issue(8'd0, 1'b0, 1'b0, "R1");   // cold, way 0 first
        issue(8'd8, 1'b0, 1'b1, "R5");   // remaining invalid way
        issue(8'd0, 1'b1, 1'b0, "R3");
        issue(8'd6, 1'b0, 1'b1, "R6");   // LRU victim is way 1
        issue(8'd8, 1'b0, 1'b0, "R7");   // LRU victim is way 0
        issue(8'd6, 1'b1, 1'b1, "R3");
        issue(8'd8, 1'b1, 1'b0, "R6");
        // set 1, with an ignored request for block 3 during the refill
        issue(8'd1, 1'b0, 1'b0, "R2", 1'b1, 8'd3);
        issue(8'd6, 1'b1, 1'b1, "R2");   // set 0 untouched
        issue(8'd3, 1'b0, 1'b1, "R8");   // was not filled by the ignored request
        issue(8'd1, 1'b1, 1'b0, "R3");
        issue(8'd5, 1'b0, 1'b1, "R6");   // evicts 3
        issue(8'd3, 1'b0, 1'b0, "R6");   // evicts 1
        issue(8'd5, 1'b1, 1'b1, "R3");
        issue(8'd10, 1'b0, 1'b0, "R6");  // evicts 8 in set 0
        issue(8'd6, 1'b1, 1'b1, "R6");
        issue(8'd8, 1'b0, 1'b0, "R6");   // evicts 10

        repeat (REFILL_LAT + 3) @(negedge clk);
        check(sb.size() == 0, "R9", "responses still outstanding", sb.size(), 0);
        check(mem_req == 1'b0 && resp_valid == 1'b0, "R9", "quiet at end",
              {mem_req, resp_valid}, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule